// File: doc/BRIEF.md
# ADC Conversion and Calibration Sequencer

This block is the timing controller for a multi-pass sampling analog-to-digital converter. It samples a start-convert input on every clock edge and drives the hold command of the track/hold. It times each conversion with a single phase counter, and it tells the datapath when a result may be captured. When the converter is asked to recalibrate, the block decides when that may begin. Calibration is modelled as a busy interval whose length is a parameter. After each calibration a fixed recovery interval lets the track/hold settle before sampling resumes.

A conversion lasts a hold phase followed by a gap phase. The gap is chosen so that a start-convert held high gives back-to-back conversions at the full rate. Start requests that arrive during a conversion or during recovery are dropped. A calibrate request is never dropped while the converter is busy with a conversion: it is latched and served at the next decision point, and it always wins over start-convert there. The calibrate input is active low and asynchronous, so it passes through a synchroniser first.

Top module: `conv_cal_seq`

## Requirements
- R1: A synchronous reset puts the block in idle: hold, capture enable, end-of-conversion, conversion-done and calibration status all low, and no calibrate request pending. A calibrate pulse that ends while reset is held has no effect after reset.
- R2: When idle, a conversion begins on the first rising edge at which start_i is sampled high. That edge drives hold_o high.
- R3: hold_o stays high for exactly HOLD_CYCLES cycles (13 by default). cap_en_o is a one-cycle pulse in the last cycle with hold high. eoc_o is a one-cycle pulse in the first cycle after hold falls.
- R4: A conversion occupies HOLD_CYCLES + GAP_CYCLES cycles (20 by default). conv_done_o is high in its last cycle only. With start_i held high, hold_o rises every 20 cycles.
- R5: start_i is ignored for the whole conversion, including the GAP_CYCLES cycles (7 by default) after hold falls. The first edge that can start a new conversion is the one that ends the current conversion.
- R6: cal_n_i passes through a two-flop synchroniser. With the block idle, a low applied just before edge k makes cal_status_o rise at edge k+2.
- R7: A calibrate low seen during a conversion is latched. Calibration then starts on the edge that ends that conversion.
- R8: At every decision point (idle, end of conversion, end of recovery) a calibrate request wins over start_i.
- R9: cal_status_o stays high for exactly CAL_CYCLES cycles per calibration. A calibrate pulse while status is high, released before the calibration ends, has no effect.
- R10: If cal_n_i is still low when a calibration ends, another calibration follows with no drop in cal_status_o. Once cal_n_i is released, the calibration in progress still runs to its end.
- R11: After calibration status falls, RECOV_CYCLES cycles (17 by default) pass during which start_i is ignored. A start_i held high begins a conversion on edge RECOV_CYCLES after status falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-convert request, sampled on each rising edge |
| cal_n_i | input | 1 | Calibrate request, active low, asynchronous |
| hold_o | output | 1 | Hold command to the track/hold |
| cap_en_o | output | 1 | One-cycle enable for the datapath to capture the result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse after hold falls |
| conv_done_o | output | 1 | High in the final cycle of a conversion |
| cal_status_o | output | 1 | High while calibration runs |

## Verification
Several properties are checked on every cycle. Hold and calibration status are never high together, and the three pulses never overlap. End-of-conversion always follows a capture and a falling hold. A new hold never rises while a calibrate request is visible, or in any state other than idle or the last cycle of a phase. A calibrate pulse during calibration never sets the pending flag, and the synchroniser output falls only two edges after the input does. Exact lengths can only be shown by the bench's scenarios: the 13-cycle hold, the 20-cycle rate, the calibration and recovery lengths, how a latched request is served at the end of a conversion, and repetition under a held-low calibrate.

// File: rtl/conv_cal_pkg.sv
package conv_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_CAL   = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cal_req_sync.sv
module cal_req_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cal_n_i,
    output logic req_lvl_o,
    output logic req_fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d;
    logic [SH_W-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], cal_n_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign req_lvl_o  = ~sh_q[SYNC_STAGES-1];
    assign req_fall_o = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

    // R6
    sync_latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (SYNC_STAGES == 2 && $fell(sh_q[1])) |-> $past(!cal_n_i, 2));

endmodule

// File: rtl/phase_decode.sv
module phase_decode
    import conv_cal_pkg::*;
#(
    parameter int HOLD_CYCLES  = 13,
    parameter int CONV_CYCLES  = 20,
    parameter int CAL_CYCLES   = 150000,
    parameter int RECOV_CYCLES = 17,
    parameter int CNT_W        = 18
) (
    input  seq_state_e        state_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              hold_o,
    output logic              cap_en_o,
    output logic              eoc_o,
    output logic              conv_done_o,
    output logic              cal_status_o,
    output logic              last_o
);
    localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CAP_IDX   = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(RECOV_CYCLES - 1);

    logic in_conv;

    always_comb begin
        in_conv      = (state_i == ST_CONV);
        hold_o       = in_conv && (cnt_i < HOLD_END);
        cap_en_o     = in_conv && (cnt_i == CAP_IDX);
        eoc_o        = in_conv && (cnt_i == HOLD_END);
        conv_done_o  = in_conv && (cnt_i == CONV_LAST);
        cal_status_o = (state_i == ST_CAL);
        unique case (state_i)
            ST_CONV:  last_o = (cnt_i == CONV_LAST);
            ST_CAL:   last_o = (cnt_i == CAL_LAST);
            ST_RECOV: last_o = (cnt_i == REC_LAST);
            default:  last_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
    import conv_cal_pkg::*;
#(
    parameter int HOLD_CYCLES  = 13,
    parameter int GAP_CYCLES   = 7,
    parameter int CAL_CYCLES   = 150000,
    parameter int RECOV_CYCLES = 17
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic cal_n_i,
    output logic hold_o,
    output logic cap_en_o,
    output logic eoc_o,
    output logic conv_done_o,
    output logic cal_status_o
);
    localparam int CONV_CYCLES = HOLD_CYCLES + GAP_CYCLES;
    localparam int LEN_A       = (CONV_CYCLES > RECOV_CYCLES) ? CONV_CYCLES : RECOV_CYCLES;
    localparam int LEN_MAX     = (CAL_CYCLES > LEN_A) ? CAL_CYCLES : LEN_A;
    localparam int CNT_W       = $clog2(LEN_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } seq_regs_t;

    seq_regs_t cur_q;
    seq_regs_t nxt_d;

    logic cal_lvl;
    logic cal_fall;
    logic cal_req;
    logic phase_last;
    logic dispatch;
    logic go_cal;

    cal_req_sync #(
        .SYNC_STAGES(2)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cal_n_i   (cal_n_i),
        .req_lvl_o (cal_lvl),
        .req_fall_o(cal_fall)
    );

    phase_decode #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .CONV_CYCLES (CONV_CYCLES),
        .CAL_CYCLES  (CAL_CYCLES),
        .RECOV_CYCLES(RECOV_CYCLES),
        .CNT_W       (CNT_W)
    ) u_dec (
        .state_i     (cur_q.st),
        .cnt_i       (cur_q.cnt),
        .hold_o      (hold_o),
        .cap_en_o    (cap_en_o),
        .eoc_o       (eoc_o),
        .conv_done_o (conv_done_o),
        .cal_status_o(cal_status_o),
        .last_o      (phase_last)
    );

    assign cal_req = cur_q.pend | cal_lvl;

    always_comb begin
        nxt_d    = cur_q;
        dispatch = 1'b0;
        go_cal   = 1'b0;

        unique case (cur_q.st)
            ST_IDLE: dispatch = 1'b1;
            ST_CONV, ST_RECOV: begin
                if (phase_last) dispatch = 1'b1;
                else            nxt_d.cnt = cur_q.cnt + 1'b1;
            end
            ST_CAL: begin
                if (phase_last) begin
                    if (cal_req) begin
                        go_cal = 1'b1;
                    end else begin
                        nxt_d.st  = ST_RECOV;
                        nxt_d.cnt = '0;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: dispatch = 1'b1;
        endcase

        // decision point: calibration always ahead of a conversion
        if (dispatch) begin
            nxt_d.cnt = '0;
            if (cal_req)      go_cal   = 1'b1;
            else if (start_i) nxt_d.st = ST_CONV;
            else              nxt_d.st = ST_IDLE;
        end

        if (go_cal) begin
            nxt_d.st   = ST_CAL;
            nxt_d.cnt  = '0;
            nxt_d.pend = 1'b0;
        end else if (cal_fall && cur_q.st != ST_CAL) begin
            nxt_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.st   <= ST_IDLE;
            cur_q.cnt  <= '0;
            cur_q.pend <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2
    hold_cal_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hold_o && cal_status_o));

    // R3
    eoc_after_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        eoc_o |-> ($past(hold_o) && !hold_o));

    // R3
    cap_then_eoc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_en_o |=> eoc_o);

    // R4
    pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({cap_en_o, eoc_o, conv_done_o}));

    // R5
    hold_rise_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_o) |-> ($past(cur_q.st == ST_IDLE) || $past(phase_last)));

    // R8
    cal_beats_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold_o) |-> !$past(cal_req));

    // R6
    cal_rise_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cal_status_o) |-> $past(cal_req));

    // R9
    cal_pulse_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_q.st == ST_CAL && !phase_last) |=> !cur_q.pend);

endmodule

// File: tb/conv_cal_seq_tb_top.sv
module conv_cal_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 13;
    localparam int GAP   = 7;
    localparam int CONV  = HOLD + GAP;
    localparam int CALN  = 40;
    localparam int RECOV = 17;

    localparam int K_HOLD = 0;
    localparam int K_CAP  = 1;
    localparam int K_EOC  = 2;
    localparam int K_DONE = 3;
    localparam int K_CALR = 4;
    localparam int K_CALF = 5;

    typedef struct {
        int    cyc;
        int    kind;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cal_n = 1'b1;
    logic hold, cap_en, eoc, conv_done, cal_status;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    int  hlen = 0;
    bit  hold_prev = 1'b0;
    bit  cal_prev = 1'b0;
    bit  finished = 1'b0;
    ev_t exp_q[$];

    conv_cal_seq #(
        .HOLD_CYCLES (HOLD),
        .GAP_CYCLES  (GAP),
        .CAL_CYCLES  (CALN),
        .RECOV_CYCLES(RECOV)
    ) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .cal_n_i     (cal_n),
        .hold_o      (hold),
        .cap_en_o    (cap_en),
        .eoc_o       (eoc),
        .conv_done_o (conv_done),
        .cal_status_o(cal_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(int t, int k, string req);
        ev_t e;
        e.cyc = t; e.kind = k; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_conv(int t0, string req);
        push(t0, K_HOLD, req);
        push(t0 + HOLD - 1, K_CAP, "R3");
        push(t0 + HOLD, K_EOC, "R3");
        push(t0 + CONV - 1, K_DONE, "R4");
    endtask

    task automatic seen(int k);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R5", $sformatf("unexpected event kind %0d", k), cyc, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == k, e.req, "event kind", k, e.kind);
            chk(e.cyc == cyc, e.req, $sformatf("event %0d cycle", k), cyc, e.cyc);
        end
    endtask

    // monitor: compares observed events with the expected queue
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (hold && !hold_prev)             seen(K_HOLD);
            if (cap_en)                         seen(K_CAP);
            if (eoc)                            seen(K_EOC);
            if (conv_done)                      seen(K_DONE);
            if (cal_status && !cal_prev)        seen(K_CALR);
            if (!cal_status && cal_prev)        seen(K_CALF);
            if (hold) begin
                hlen++;
            end else if (hold_prev) begin
                chk(hlen == HOLD, "R3", "hold length", hlen, HOLD);
                hlen = 0;
            end
        end
        hold_prev = hold;
        cal_prev  = cal_status;
    end

    task automatic wait_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int c;
        int ec;
        // R1: reset state, cal pulse during reset leaves nothing pending
        repeat (3) @(negedge clk);
        cal_n = 1'b0;
        @(negedge clk);
        cal_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({hold, cap_en, eoc, conv_done, cal_status} == 5'b0, "R1", "outputs in reset",
            {hold, cap_en, eoc, conv_done, cal_status}, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(cal_status == 1'b0, "R1", "status after reset", cal_status, 0);
        chk(hold == 1'b0, "R1", "hold after reset", hold, 0);

        // R2: single start pulse
        c = cyc;
        start = 1'b1;
        push_conv(c + 1, "R2");
        @(negedge clk);
        start = 1'b0;
        wait_until(c + 25);

        // R4: back-to-back with start held high
        c = cyc;
        start = 1'b1;
        push_conv(c + 1, "R4");
        push_conv(c + 1 + CONV, "R4");
        push_conv(c + 1 + 2 * CONV, "R4");
        wait_until(c + 1 + 2 * CONV);
        start = 1'b0;
        wait_until(c + 3 * CONV + 6);

        // R5: start pulses inside hold and gap are dropped
        c = cyc;
        start = 1'b1;
        push_conv(c + 1, "R2");
        @(negedge clk);
        start = 1'b0;
        wait_until(c + 5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_until(c + 15);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_until(c + 19);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_until(c + 23);
        chk(hold == 1'b0, "R5", "hold after ignored starts", hold, 0);
        wait_until(c + 26);

        // R6 R9 R11: idle calibrate, pulse during status, recovery
        c = cyc;
        cal_n = 1'b0;
        @(negedge clk);
        cal_n = 1'b1;
        ec = c + 3 + CALN;
        push(c + 3, K_CALR, "R6");
        push(ec, K_CALF, "R9");
        push_conv(ec + RECOV, "R11");
        wait_until(c + 10);
        cal_n = 1'b0;
        @(negedge clk);
        cal_n = 1'b1;
        wait_until(c + 12);
        start = 1'b1;
        wait_until(ec + 2);
        chk(cal_status == 1'b0, "R9", "no repeat after pulse in status", cal_status, 0);
        wait_until(ec + RECOV - 1);
        chk(hold == 1'b0, "R11", "hold during recovery", hold, 0);
        wait_until(ec + RECOV);
        start = 1'b0;
        wait_until(ec + RECOV + CONV + 3);

        // R7 R8: request latched in a conversion wins over held start
        c = cyc;
        start = 1'b1;
        push_conv(c + 1, "R2");
        ec = c + 1 + CONV + CALN;
        push(c + 1 + CONV, K_CALR, "R7");
        push(ec, K_CALF, "R9");
        push_conv(ec + RECOV, "R8");
        wait_until(c + 5);
        cal_n = 1'b0;
        @(negedge clk);
        cal_n = 1'b1;
        wait_until(c + 1 + CONV);
        chk(hold == 1'b0 && cal_status == 1'b1, "R8", "calibration chosen over start",
            {hold, cal_status}, 1);
        wait_until(ec + RECOV);
        start = 1'b0;
        wait_until(ec + RECOV + CONV + 3);

        // R10: calibrate held low repeats without status dropping
        c = cyc;
        cal_n = 1'b0;
        push(c + 3, K_CALR, "R10");
        push(c + 3 + 2 * CALN, K_CALF, "R10");
        wait_until(c + 3 + CALN);
        chk(cal_status == 1'b1, "R10", "status across repeat", cal_status, 1);
        wait_until(c + 3 + CALN + 5);
        cal_n = 1'b1;
        wait_until(c + 3 + 2 * CALN + RECOV + 4);
        chk(hold == 1'b0 && cal_status == 1'b0, "R10", "idle after release",
            {hold, cal_status}, 0);

        chk(exp_q.size() == 0, "R2", "expected events left over", exp_q.size(), 0);
        finish_run();
    end

endmodule